// File: doc/BRIEF.md
# Breakpoint trigger response controller

This block sits between the breakpoint comparators and the core's sequencing logic. It counts breakpoint hits against an armed configuration. There are two arming levels, and each level has its own status code. When the final level is reached, the block carries out the response chosen by a two-bit response field. The response is either a halt that lasts until the core is resumed, or a debug interrupt that ranks above every external interrupt level.

A debug interrupt is only taken at an instruction boundary. A program-counter hit is counted only on a boundary cycle. Because of this, a program-counter breakpoint with the interrupt response is taken in the same cycle, before the targeted instruction runs. Address or data hits count in any cycle, so their interrupt stays pending until the next boundary. Taking the debug interrupt enters emulator mode. While that mode lasts, every interrupt request is ignored. The mode ends when the core reports that a return-from-exception has completed. The breakpoint status is driven on a 4-bit debug-data output and is mirrored into the top nibble of a 32-bit status word.

Top module: `bkpt_resp_ctrl`

## Requirements
- R1: After reset the status code is 0, halt is low, the processor status output is 0, emulator mode is off, and no request is pending.
- R2: An arm strobe loads a new mode. Mode 1 (single level) and mode 2 (two levels) set the status to 1 on the next clock. Modes 0 and 3 set it to 0. The arm strobe wins over a trigger in the same cycle.
- R3: In single-level mode, a trigger while the status is 1 sets the status to 2 and fires the response. Further triggers are ignored.
- R4: In two-level mode, the first trigger moves the status from 1 to 5 and fires no response. A trigger while the status is 5 sets it to 6 and fires the response.
- R5: With response field 1, a fired response raises halt on the next clock. The processor status output reads 0xF while halt is high and 0 otherwise. Halt stays high until a resume pulse clears it on the following clock.
- R6: With response field 2, a fired response requests a debug interrupt. The request is taken at the first instruction-boundary cycle outside emulator mode, with vector 0x0C. It outranks an external level-7 request, and taking it clears the pending request.
- R7: A program-counter hit counts only in an instruction-boundary cycle. An address/data hit counts in any cycle. A program-counter hit that fires the interrupt response is taken in that same cycle.
- R8: Response field values 0 and 3 fire nothing beyond the status change: halt stays low and no interrupt is taken.
- R9: Taking the debug interrupt turns emulator mode on at the next clock. While the mode is on, no interrupt of any kind is taken. A return-complete pulse turns the mode off at the next clock.
- R10: The 4-bit status is driven on the debug-data output and on bits 31:28 of the status word. Bits 27:0 of the status word are zero.
- R11: With no debug request, outside emulator mode, an external level L (1 to 7) is taken at an instruction boundary with vector 24+L, and emulator mode does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Load arming mode strobe |
| arm_mode_i | input | 2 | 0 off, 1 single level, 2 two levels, 3 off |
| resp_sel_i | input | 2 | Response field: 1 halt, 2 debug interrupt, 0/3 none |
| pc_hit_i | input | 1 | Program-counter comparator hit |
| ad_hit_i | input | 1 | Address/data comparator hit |
| insn_bnd_i | input | 1 | Instruction boundary / interrupt sampling strobe |
| irq_lvl_i | input | 3 | External interrupt level, 0 = none |
| rte_done_i | input | 1 | Return-from-exception completed |
| resume_i | input | 1 | Resume pulse that ends a halt |
| halt_o | output | 1 | Core halt request |
| pst_o | output | 4 | Processor status, 0xF while halted |
| take_vld_o | output | 1 | Interrupt taken this cycle |
| take_vec_o | output | 8 | Vector number of the taken interrupt |
| emu_o | output | 1 | Emulator mode active |
| ddata_o | output | 4 | Breakpoint status code |
| csr_stat_o | output | 32 | Status word, status code in bits 31:28 |

## Verification
A wrong level state shows within one clock on the debug-data and status-word outputs as a code outside the legal set or as the wrong one of 1/5/2/6. A lost or stale pending request shows at the next boundary cycle: the take strobe is missing, or it carries vector 0x0C when it should not. A wrong emulator-mode flag shows the same way at the next boundary, because the flag decides whether a level-7 request is taken. A halt that drops early or never clears is visible on the halt and processor-status outputs in the cycle after the resume pulse.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int STAT_W = 4;

  typedef enum logic [STAT_W-1:0] {
    ST_OFF   = 4'h0,
    ST_WAIT1 = 4'h1,
    ST_TRIG1 = 4'h2,
    ST_WAIT2 = 4'h5,
    ST_TRIG2 = 4'h6
  } bk_stat_e;

  typedef enum logic [1:0] {
    MD_OFF    = 2'd0,
    MD_SINGLE = 2'd1,
    MD_DOUBLE = 2'd2,
    MD_RSVD   = 2'd3
  } bk_mode_e;

  localparam logic [1:0] RESP_HALT = 2'd1;
  localparam logic [1:0] RESP_IRQ  = 2'd2;
endpackage

// File: rtl/bkpt_status_fsm.sv
module bkpt_status_fsm
  import bkpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic [1:0]        arm_mode_i,
  input  logic              trig_i,
  output logic              fire_o,
  output logic [STAT_W-1:0] stat_o
);
  bk_stat_e stat_q, stat_d;
  logic     two_lvl_q, two_lvl_d;
  logic     upd_en;

  always_comb begin
    stat_d    = stat_q;
    two_lvl_d = two_lvl_q;
    fire_o    = 1'b0;
    if (arm_i) begin
      two_lvl_d = (arm_mode_i == MD_DOUBLE);
      if (arm_mode_i == MD_SINGLE || arm_mode_i == MD_DOUBLE) stat_d = ST_WAIT1;
      else stat_d = ST_OFF;
    end else if (trig_i) begin
      unique case (stat_q)
        ST_WAIT1: begin
          if (two_lvl_q) stat_d = ST_WAIT2;
          else begin
            stat_d = ST_TRIG1;
            fire_o = 1'b1;
          end
        end
        ST_WAIT2: begin
          stat_d = ST_TRIG2;
          fire_o = 1'b1;
        end
        default: stat_d = stat_q;
      endcase
    end
  end

  assign upd_en = arm_i | trig_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q    <= ST_OFF;
      two_lvl_q <= 1'b0;
    end else if (upd_en) begin
      stat_q    <= stat_d;
      two_lvl_q <= two_lvl_d;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/bkpt_resp_unit.sv
module bkpt_resp_unit
  import bkpt_pkg::*;
#(
  parameter int LVL_W    = 3,
  parameter int VEC_W    = 8,
  parameter int DBG_VEC  = 12,
  parameter int AUTO_BASE = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic [1:0]       resp_sel_i,
  input  logic             insn_bnd_i,
  input  logic [LVL_W-1:0] irq_lvl_i,
  input  logic             emu_i,
  input  logic             resume_i,
  output logic             halt_o,
  output logic             take_dbg_o,
  output logic             take_vld_o,
  output logic [VEC_W-1:0] take_vec_o
);
  logic halt_q, halt_d;
  logic pend_q, pend_d;
  logic fire_halt, fire_irq, dbg_req, take_ext, sample_ok;

  assign fire_halt = fire_i && (resp_sel_i == RESP_HALT);
  assign fire_irq  = fire_i && (resp_sel_i == RESP_IRQ);
  assign dbg_req   = pend_q | fire_irq;
  assign sample_ok = insn_bnd_i && !emu_i;

  always_comb begin
    take_dbg_o = sample_ok && dbg_req;
    take_ext   = sample_ok && !dbg_req && (irq_lvl_i != '0);
    take_vld_o = take_dbg_o | take_ext;
    if (take_dbg_o) take_vec_o = VEC_W'(DBG_VEC);
    else if (take_ext) take_vec_o = VEC_W'(AUTO_BASE) + VEC_W'(irq_lvl_i);
    else take_vec_o = '0;

    halt_d = halt_q;
    if (fire_halt) halt_d = 1'b1;
    else if (resume_i) halt_d = 1'b0;

    pend_d = pend_q;
    if (take_dbg_o) pend_d = 1'b0;
    else if (fire_irq) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      halt_q <= halt_d;
      pend_q <= pend_d;
    end
  end

  assign halt_o = halt_q;
endmodule

// File: rtl/bkpt_emu_trk.sv
module bkpt_emu_trk (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_i,
  input  logic leave_i,
  output logic emu_o
);
  logic emu_q, emu_d;

  always_comb begin
    emu_d = emu_q;
    if (enter_i) emu_d = 1'b1;
    else if (leave_i) emu_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) emu_q <= 1'b0;
    else        emu_q <= emu_d;
  end

  assign emu_o = emu_q;
endmodule

// File: rtl/bkpt_resp_ctrl.sv
module bkpt_resp_ctrl
  import bkpt_pkg::*;
#(
  parameter int LVL_W     = 3,
  parameter int VEC_W     = 8,
  parameter int CSR_W     = 32,
  parameter int DBG_VEC   = 12,
  parameter int AUTO_BASE = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic [1:0]       arm_mode_i,
  input  logic [1:0]       resp_sel_i,
  input  logic             pc_hit_i,
  input  logic             ad_hit_i,
  input  logic             insn_bnd_i,
  input  logic [LVL_W-1:0] irq_lvl_i,
  input  logic             rte_done_i,
  input  logic             resume_i,
  output logic             halt_o,
  output logic [3:0]       pst_o,
  output logic             take_vld_o,
  output logic [VEC_W-1:0] take_vec_o,
  output logic             emu_o,
  output logic [STAT_W-1:0] ddata_o,
  output logic [CSR_W-1:0] csr_stat_o
);
  localparam int LOW_W = CSR_W - STAT_W;

  logic trig, fire, take_dbg;
  logic [STAT_W-1:0] stat;

  assign trig = (pc_hit_i && insn_bnd_i) || ad_hit_i;

  bkpt_status_fsm u_stat (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .arm_mode_i(arm_mode_i),
    .trig_i(trig), .fire_o(fire), .stat_o(stat)
  );

  bkpt_resp_unit #(
    .LVL_W(LVL_W), .VEC_W(VEC_W), .DBG_VEC(DBG_VEC), .AUTO_BASE(AUTO_BASE)
  ) u_resp (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .resp_sel_i(resp_sel_i),
    .insn_bnd_i(insn_bnd_i), .irq_lvl_i(irq_lvl_i), .emu_i(emu_o),
    .resume_i(resume_i), .halt_o(halt_o), .take_dbg_o(take_dbg),
    .take_vld_o(take_vld_o), .take_vec_o(take_vec_o)
  );

  bkpt_emu_trk u_emu (
    .clk(clk), .rst_n(rst_n), .enter_i(take_dbg), .leave_i(rte_done_i),
    .emu_o(emu_o)
  );

  assign pst_o      = halt_o ? 4'hF : 4'h0;
  assign ddata_o    = stat;
  assign csr_stat_o = {stat, {LOW_W{1'b0}}};
endmodule

// File: rtl/bkpt_resp_ctrl_chk.sv
module bkpt_resp_ctrl_chk #(
  parameter int VEC_W = 8,
  parameter int CSR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             halt_o,
  input logic [3:0]       pst_o,
  input logic             take_vld_o,
  input logic [VEC_W-1:0] take_vec_o,
  input logic             emu_o,
  input logic [3:0]       ddata_o,
  input logic [CSR_W-1:0] csr_stat_o,
  input logic             resume_i
);
  p_pst_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> (pst_o == 4'hF));

  p_halt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_o && !resume_i) |=> halt_o);

  p_no_take_emu_r9: assert property (@(posedge clk) disable iff (!rst_n)
    emu_o |-> !take_vld_o);

  p_emu_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(emu_o) |-> $past(take_vld_o && take_vec_o == VEC_W'(12)));

  p_legal_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ddata_o inside {4'h0, 4'h1, 4'h2, 4'h5, 4'h6});

  p_csr_mirror_r10: assert property (@(posedge clk) disable iff (!rst_n)
    csr_stat_o[CSR_W-1 -: 4] == ddata_o);
endmodule

bind bkpt_resp_ctrl bkpt_resp_ctrl_chk #(.VEC_W(VEC_W), .CSR_W(CSR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .halt_o(halt_o), .pst_o(pst_o),
  .take_vld_o(take_vld_o), .take_vec_o(take_vec_o), .emu_o(emu_o),
  .ddata_o(ddata_o), .csr_stat_o(csr_stat_o), .resume_i(resume_i)
);

// File: tb/bkpt_resp_ctrl_tb_top.sv
module bkpt_resp_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int WDOG  = 2000;

  typedef struct {
    string      tag;
    logic [3:0] dd;
    logic       halt;
    logic       take;
    logic [7:0] vec;
    logic       emu;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 0, pc = 0, ad = 0, bnd = 0, rte = 0, res = 0;
  logic [1:0] mode = 0, trc = 0;
  logic [2:0] lvl = 0;
  logic halt_o, take_vld_o, emu_o;
  logic [3:0] pst_o, ddata_o;
  logic [7:0] take_vec_o;
  logic [31:0] csr_stat_o;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  bkpt_resp_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .arm_mode_i(mode), .resp_sel_i(trc),
    .pc_hit_i(pc), .ad_hit_i(ad), .insn_bnd_i(bnd), .irq_lvl_i(lvl),
    .rte_done_i(rte), .resume_i(res), .halt_o(halt_o), .pst_o(pst_o),
    .take_vld_o(take_vld_o), .take_vec_o(take_vec_o), .emu_o(emu_o),
    .ddata_o(ddata_o), .csr_stat_o(csr_stat_o)
  );

  task automatic step(input logic a, input logic [1:0] m, input logic [1:0] t,
                      input logic p, input logic d, input logic b,
                      input logic [2:0] l, input logic r, input logic s,
                      input logic [3:0] e_dd, input logic e_h, input logic e_tk,
                      input logic [7:0] e_v, input logic e_em, input string tag);
    exp_t it;
    @(negedge clk);
    arm = a; mode = m; trc = t; pc = p; ad = d; bnd = b; lvl = l; rte = r; res = s;
    it.tag = tag; it.dd = e_dd; it.halt = e_h; it.take = e_tk; it.vec = e_v; it.emu = e_em;
    q.push_back(it);
  endtask

  task automatic idle(input logic [3:0] e_dd, input logic e_h, input logic e_em,
                      input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, e_dd, e_h, 0, 8'h00, e_em, tag);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      while (q.size() > 0) begin
        exp_t e;
        logic [31:0] e_csr;
        logic [3:0] e_pst;
        e = q.pop_front();
        e_csr = {e.dd, 28'h0};
        e_pst = e.halt ? 4'hF : 4'h0;
        n_chk++;
        if (ddata_o !== e.dd || csr_stat_o !== e_csr || halt_o !== e.halt ||
            pst_o !== e_pst || take_vld_o !== e.take || take_vec_o !== e.vec ||
            emu_o !== e.emu) begin
          n_fail++;
          $display("FAIL %s: got dd=%h csr=%h halt=%b pst=%h take=%b vec=%h emu=%b exp dd=%h csr=%h halt=%b pst=%h take=%b vec=%h emu=%b",
                   e.tag, ddata_o, csr_stat_o, halt_o, pst_o, take_vld_o, take_vec_o, emu_o,
                   e.dd, e_csr, e.halt, e_pst, e.take, e.vec, e.emu);
        end
      end
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(0, 0, 0, "R1 reset state");
    // single level, halt response
    step(1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00, 0, "R2 arm cycle");
    idle(1, 0, 0, "R2 single armed code 1");
    step(0, 0, 1, 1, 0, 0, 0, 0, 0, 1, 0, 0, 8'h00, 0, "R7 pc hit off boundary");
    idle(1, 0, 0, "R7 pc hit ignored");
    step(0, 0, 1, 0, 1, 0, 0, 0, 0, 1, 0, 0, 8'h00, 0, "R3 ad hit");
    idle(2, 1, 0, "R3 R5 triggered and halted");
    step(0, 0, 1, 0, 1, 0, 0, 0, 0, 2, 1, 0, 8'h00, 0, "R3 second hit");
    idle(2, 1, 0, "R3 extra hit ignored R10");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 1, 0, 8'h00, 0, "R5 resume cycle");
    idle(2, 0, 0, "R5 halt cleared");
    // two levels, interrupt response, PC hit on boundary
    step(1, 2, 2, 0, 0, 0, 0, 0, 0, 2, 0, 0, 8'h00, 0, "R2 arm two-level");
    idle(1, 0, 0, "R2 two-level code 1");
    step(0, 0, 2, 0, 1, 0, 0, 0, 0, 1, 0, 0, 8'h00, 0, "R4 first level hit");
    step(0, 0, 2, 0, 0, 1, 0, 0, 0, 5, 0, 0, 8'h00, 0, "R4 code 5 no response");
    step(0, 0, 2, 1, 0, 1, 0, 0, 0, 5, 0, 1, 8'h0C, 0, "R7 R6 pc hit taken same cycle");
    idle(6, 0, 1, "R4 R9 code 6 emu on");
    step(0, 0, 0, 0, 0, 1, 7, 0, 0, 6, 0, 0, 8'h00, 1, "R9 level 7 ignored in emu");
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 6, 0, 0, 8'h00, 1, "R9 rte cycle");
    step(0, 0, 0, 0, 0, 1, 7, 0, 0, 6, 0, 1, 8'h1F, 0, "R11 level 7 autovector");
    step(0, 0, 0, 0, 0, 1, 3, 0, 0, 6, 0, 1, 8'h1B, 0, "R11 level 3 no emu");
    // single level, interrupt pending from ad hit
    step(1, 1, 2, 0, 0, 0, 0, 0, 0, 6, 0, 0, 8'h00, 0, "R2 rearm");
    idle(1, 0, 0, "R2 rearmed");
    step(0, 0, 2, 0, 1, 0, 7, 0, 0, 1, 0, 0, 8'h00, 0, "R6 ad hit no boundary");
    step(0, 0, 2, 0, 0, 1, 7, 0, 0, 2, 0, 1, 8'h0C, 0, "R6 debug beats level 7");
    idle(2, 0, 1, "R9 emu entered");
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 2, 0, 0, 8'h00, 1, "R9 rte");
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 2, 0, 0, 8'h00, 0, "R6 pending cleared");
    // no-response field values
    step(1, 1, 0, 0, 0, 0, 0, 0, 0, 2, 0, 0, 8'h00, 0, "R8 arm field 0");
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 1, 0, 0, 8'h00, 0, "R8 hit field 0");
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 2, 0, 0, 8'h00, 0, "R8 field 0 no response");
    step(1, 1, 3, 0, 0, 0, 0, 0, 0, 2, 0, 0, 8'h00, 0, "R8 arm field 3");
    step(0, 0, 3, 0, 1, 0, 0, 0, 0, 1, 0, 0, 8'h00, 0, "R8 hit field 3");
    step(0, 0, 3, 0, 0, 1, 0, 0, 0, 2, 0, 0, 8'h00, 0, "R8 field 3 no response");
    // arm beats trigger, disable modes
    step(1, 1, 1, 0, 1, 0, 0, 0, 0, 2, 0, 0, 8'h00, 0, "R2 arm with hit");
    idle(1, 0, 0, "R2 arm wins over hit");
    step(1, 3, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 8'h00, 0, "R2 mode 3");
    idle(0, 0, 0, "R2 mode 3 off");
    step(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00, 0, "R2 arm again");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 8'h00, 0, "R2 mode 0");
    idle(0, 0, 0, "R2 mode 0 off");
    @(negedge clk);
    #(CLK_P/2);
    done = 1;
  end

  initial begin : finish_ctl
    int cyc = 0;
    while (!done && cyc < WDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule